// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block recovers asynchronous serial characters from a single receive line. An external strobe marks each oversampling instant. The line first passes through a two-stage synchronizer. It is then examined only on strobe cycles. Each bit cell lasts 16 strobes in normal mode and 8 strobes in double-speed mode. The value of every bit, the start and stop bits included, is the majority of three consecutive samples taken around the middle of the cell.

A frame is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional even or odd parity bit, then a stop bit. Only the first stop bit is examined. The receiver re-arms as soon as that bit's last voting sample has been taken. When a frame completes, the block raises a one-cycle valid strobe. The data word and two error flags (frame error and parity error) change on that strobe and hold their values until the next one.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `frame_err` and `par_err` are all zero.
- R2: With `dbl_speed`=0, a bit cell is 16 strobes. Sample 1 is the strobe on which the synchronized line is first seen low after being high. Each bit is the majority of samples 8, 9 and 10 of its cell.
- R3: With `dbl_speed`=1, a bit cell is 8 strobes and each bit is the majority of samples 4, 5 and 6 of its cell.
- R4: `char_sel` selects the number of data bits: code 0 gives 5, code 1 gives 6, code 2 gives 7, code 3 gives 8, and codes 4 to 7 give 9. The first data bit received lands in `rx_data[0]`, and data bits above the selected size read zero.
- R5: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the data bits and parity bit must hold an even number of ones; with `par_odd`=1 they must hold an odd number. `par_err` is 1 on a mismatch and is always 0 when `par_en`=0.
- R6: If the vote on the stop bit is 0, `frame_err` is 1 for that frame, and the data word is still delivered.
- R7: Only the first stop bit is examined; a line that stays high for further stop-bit times produces no extra frame.
- R8: A new start edge is accepted from the strobe right after the last stop-bit voting sample, so a stop bit only a little longer than its voting window still lets the next frame decode.
- R9: If the vote on the start bit reads 1, the start is discarded, the receiver returns to idle and no frame is reported.
- R10: A single-sample inversion inside any bit cell (start, data or stop) does not change the decoded frame.
- R11: `rx_valid` is high for exactly one clock per completed frame. `rx_data` and the flags change only in that cycle.
- R12: Frames whose bit rate differs from nominal by about 3% in normal mode and about 1.5% in double-speed mode, including the longest frame (9 data bits plus parity), decode correctly.
- R13: The speed mode, character size and parity settings are captured when the start edge is seen; changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe at the oversampling rate |
| dbl_speed | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| char_sel | input | 3 | Data bit count code (see R4) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 9 | Received data word, right aligned |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| frame_err | output | 1 | Stop bit voted low for the last frame |
| par_err | output | 1 | Parity mismatch for the last frame |

## Verification
The bench sends frames at nominal rate in both speed modes and for every character size. It uses good and bad parity of both senses to separate data assembly from parity checking. Stop bits are sent low, long, and cut short just past their voting window, which shows that only the first stop bit matters and that re-arming happens early. Short low pulses on an idle line, one-strobe inversions inside the start, data and stop cells, and frames sent several percent fast or slow show the voting and sample placement at work. A change of configuration in mid-frame shows that settings are captured at the start edge.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP
  } rx_state_e;

  // two-of-three vote
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // data bit count for a size code, clamped to the widest supported word
  function automatic int unsigned data_bits(input logic [2:0] code,
                                            input int unsigned lo,
                                            input int unsigned hi);
    int unsigned n;
    n = lo + 32'(code);
    return (n > hi) ? hi : n;
  endfunction

  // parity bit a sender would attach, given the XOR of the data bits
  function automatic logic par_bit(input logic ones_xor, input logic odd);
    return ones_xor ^ odd;
  endfunction

endpackage

// File: rtl/umv_sync.sv
module umv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/umv_sampler.sv
module umv_sampler
  import uart_mv_pkg::*;
#(
  parameter int SPB_NORM = 16,
  parameter int SPB_DBL  = 8,
  parameter int CW       = $clog2(SPB_NORM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic dbl,
  input  logic align,
  input  logic active,
  output logic fall_seen,
  output logic vote_strb,
  output logic vote_bit
);
  localparam int VF_N = SPB_NORM / 2;
  localparam int VF_D = SPB_DBL / 2;

  logic [CW-1:0] cnt_q, cnt_nx, spb, vfirst;
  logic          prev_q;
  logic [1:0]    win_q;
  logic          in_win;

  assign spb    = dbl ? CW'(SPB_DBL) : CW'(SPB_NORM);
  assign vfirst = dbl ? CW'(VF_D)    : CW'(VF_N);

  always_comb begin
    if (align)             cnt_nx = CW'(1);
    else if (cnt_q == spb) cnt_nx = CW'(1);
    else                   cnt_nx = cnt_q + CW'(1);
  end

  assign in_win    = (cnt_nx >= vfirst) && (cnt_nx <= vfirst + CW'(2));
  assign fall_seen = tick & prev_q & ~rx;
  assign vote_strb = tick & active & ~align & (cnt_nx == vfirst + CW'(2));
  assign vote_bit  = maj3({win_q, rx});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b1;
      win_q  <= '0;
    end else if (tick) begin
      prev_q <= rx;
      if (align || active) begin
        cnt_q <= cnt_nx;
        if (in_win) win_q <= {win_q[0], rx};
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q >= CW'(1) && cnt_q <= spb));

  // R11
  vote_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_strb |=> !vote_strb);

  // R3
  align_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align |-> tick);
endmodule

// File: rtl/umv_assembler.sv
module umv_assembler #(
  parameter int DMAX = 9,
  parameter int NW   = $clog2(DMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            wr_en,
  input  logic [NW-1:0]   wr_idx,
  input  logic            bit_in,
  output logic [DMAX-1:0] word
);
  logic [DMAX-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (clear) word_q <= '0;
    else if (wr_en) word_q[wr_idx] <= bit_in;
  end

  assign word = word_q;

  // R4
  wr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < NW'(DMAX)));
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import uart_mv_pkg::*;
#(
  parameter int DMIN        = 5,
  parameter int DMAX        = 9,
  parameter int SPB_NORM    = 16,
  parameter int SPB_DBL     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            os_tick,
  input  logic            dbl_speed,
  input  logic [2:0]      char_sel,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            rx_in,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_valid,
  output logic            frame_err,
  output logic            par_err
);
  localparam int NW = $clog2(DMAX + 1);

  rx_state_e       state_q;
  logic [NW-1:0]   idx_q, nbits_q;
  logic            dbl_q, pen_q, podd_q, pbit_q;
  logic            rx_s, fall_seen, vote_strb, vote_bit;
  logic            align, active, wr_en;
  logic [DMAX-1:0] word;

  umv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s));

  assign align  = (state_q == RS_IDLE) && fall_seen;
  assign active = (state_q != RS_IDLE);
  assign wr_en  = vote_strb && (state_q == RS_DATA);

  umv_sampler #(.SPB_NORM(SPB_NORM), .SPB_DBL(SPB_DBL)) samp_i (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .dbl(dbl_q),
    .align(align), .active(active), .fall_seen(fall_seen),
    .vote_strb(vote_strb), .vote_bit(vote_bit));

  umv_assembler #(.DMAX(DMAX), .NW(NW)) asm_i (
    .clk(clk), .rst_n(rst_n), .clear(align), .wr_en(wr_en),
    .wr_idx(idx_q), .bit_in(vote_bit), .word(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RS_IDLE;
      idx_q     <= '0;
      nbits_q   <= NW'(DMIN);
      dbl_q     <= 1'b0;
      pen_q     <= 1'b0;
      podd_q    <= 1'b0;
      pbit_q    <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state_q)
        RS_IDLE: if (align) begin
          state_q <= RS_START;
          nbits_q <= NW'(data_bits(char_sel, DMIN, DMAX));
          dbl_q   <= dbl_speed;
          pen_q   <= par_en;
          podd_q  <= par_odd;
        end
        RS_START: if (vote_strb) begin
          idx_q   <= '0;
          state_q <= vote_bit ? RS_IDLE : RS_DATA;
        end
        RS_DATA: if (vote_strb) begin
          if (idx_q == nbits_q - NW'(1)) state_q <= pen_q ? RS_PAR : RS_STOP;
          else                           idx_q   <= idx_q + NW'(1);
        end
        RS_PAR: if (vote_strb) begin
          pbit_q  <= vote_bit;
          state_q <= RS_STOP;
        end
        RS_STOP: if (vote_strb) begin
          rx_valid  <= 1'b1;
          rx_data   <= word;
          frame_err <= ~vote_bit;
          par_err   <= pen_q & (pbit_q != par_bit(^word, podd_q));
          state_q   <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(par_err)));

  // R9
  valid_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(state_q) == RS_STOP));

  // R5
  par_err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && par_err) |-> pen_q);
endmodule

// File: tb/uart_mv_rx_tb.sv
module uart_mv_rx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       dbl_speed = 1'b0;
  logic [2:0] char_sel = 3'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rx_in = 1'b1;
  logic [8:0] rx_data;
  logic       rx_valid, frame_err, par_err;

  int nchk = 0, nerr = 0, tdiv = 4, tcnt = 0;
  bit done = 0, mon_on = 0, prev_dv = 0;
  logic [8:0] last_data = '0;
  int unsigned exp_data[$];
  bit exp_fe[$], exp_pe[$];
  string exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mv_rx dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .dbl_speed(dbl_speed),
    .char_sel(char_sel), .par_en(par_en), .par_odd(par_odd), .rx_in(rx_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err), .par_err(par_err));

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % tdiv;
    os_tick <= (tcnt == 0);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference: queue of intended frames, compared against the ports every clock
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (rx_valid) begin
        chk(!prev_dv, "R11", "valid wider than one clock", 1, 0);
        if (exp_data.size() == 0) chk(0, "R11", "unexpected frame", rx_data, 0);
        else begin
          string t;
          int unsigned d;
          bit fe, pe;
          d = exp_data.pop_front(); fe = exp_fe.pop_front();
          pe = exp_pe.pop_front();  t = exp_tag.pop_front();
          chk(rx_data == d[8:0], t, "data", rx_data, d);
          chk(frame_err == fe, t, "frame_err", frame_err, fe);
          chk(par_err == pe, t, "par_err", par_err, pe);
        end
      end else if (rx_data !== last_data)
        chk(0, "R11", "data changed without valid", rx_data, last_data);
      prev_dv = rx_valid;
      last_data = rx_data;
    end
  end

  task automatic idle(input int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_low(input int n);
    rx_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // sends one frame; gbit selects a cell (0 = start) to get a one-strobe inversion
  task automatic send_frame(input int unsigned val, input int nb, input bit pe,
                            input bit podd, input bit badpar, input bit stopv,
                            input int bclk, input int stopclk, input int gbit,
                            input string tag);
    bit b[12];
    int nbits;
    int unsigned mask;
    bit p;
    mask = (1 << nb) - 1;
    p = (^(val & mask)) ^ podd ^ badpar;
    nbits = 0;
    b[nbits++] = 1'b0;
    for (int i = 0; i < nb; i++) b[nbits++] = val[i];
    if (pe) b[nbits++] = p;
    b[nbits++] = stopv;
    exp_data.push_back(val & mask); exp_fe.push_back(!stopv);
    exp_pe.push_back(pe && badpar); exp_tag.push_back(tag);
    for (int k = 0; k < nbits; k++) begin
      int len, gofs;
      len = (k == nbits - 1) ? stopclk : bclk;
      gofs = bclk / 2 - 2;
      for (int c = 0; c < len; c++) begin
        rx_in = b[k] ^ ((k == gbit) && (c >= gofs) && (c < gofs + tdiv));
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_valid == 0 && rx_data == 0 && frame_err == 0 && par_err == 0,
        "R1", "reset outputs", {rx_valid, frame_err, par_err, rx_data}, 0);
    mon_on = 1;
    idle(128);

    // R2 normal mode, 8 bits
    send_frame(32'hA5, 8, 0, 0, 0, 1, 64, 64, -1, "R2"); idle(100);
    send_frame(32'h5A, 8, 0, 0, 0, 1, 64, 64, -1, "R2"); idle(100);

    // R4 character sizes
    char_sel = 3'd0; send_frame(32'h13, 5, 0, 0, 0, 1, 64, 64, -1, "R4"); idle(100);
    char_sel = 3'd2; send_frame(32'h55, 7, 0, 0, 0, 1, 64, 64, -1, "R4"); idle(100);
    char_sel = 3'd4; send_frame(32'h1C3, 9, 0, 0, 0, 1, 64, 64, -1, "R4"); idle(100);
    char_sel = 3'd7; send_frame(32'h1AB, 9, 0, 0, 0, 1, 64, 64, -1, "R4"); idle(100);

    // R5 parity good and bad, even and odd
    char_sel = 3'd2; par_en = 1;
    par_odd = 0; send_frame(32'h35, 7, 1, 0, 0, 1, 64, 64, -1, "R5"); idle(100);
    par_odd = 1; send_frame(32'h35, 7, 1, 1, 0, 1, 64, 64, -1, "R5"); idle(100);
    par_odd = 1; send_frame(32'h4C, 7, 1, 1, 1, 1, 64, 64, -1, "R5"); idle(100);
    par_odd = 0; send_frame(32'h4C, 7, 1, 0, 1, 1, 64, 64, -1, "R5"); idle(100);
    par_en = 0; char_sel = 3'd3;

    // R6 stop bit low, line stays low a while
    send_frame(32'h3C, 8, 0, 0, 0, 0, 64, 64, -1, "R6"); hold_low(64); idle(100);

    // R7 three stop-bit times
    send_frame(32'h81, 8, 0, 0, 0, 1, 64, 192, -1, "R7");
    send_frame(32'h7E, 8, 0, 0, 0, 1, 64, 64, -1, "R7"); idle(100);

    // R8 short stop bits, back to back
    send_frame(32'hC3, 8, 0, 0, 0, 1, 64, 44, -1, "R8");
    send_frame(32'h18, 8, 0, 0, 0, 1, 64, 44, -1, "R8");
    send_frame(32'hE7, 8, 0, 0, 0, 1, 64, 64, -1, "R8"); idle(100);

    // R9 false starts, then a real frame
    hold_low(4);  idle(200);
    hold_low(12); idle(200);
    send_frame(32'h99, 8, 0, 0, 0, 1, 64, 64, -1, "R9"); idle(100);

    // R10 one-strobe inversions in start, data and stop cells
    send_frame(32'h00, 8, 0, 0, 0, 1, 64, 64, 3, "R10"); idle(100);
    send_frame(32'hFF, 8, 0, 0, 0, 1, 64, 64, 9, "R10"); idle(100);
    send_frame(32'h6D, 8, 0, 0, 0, 1, 64, 64, 0, "R10"); idle(100);

    // R3 double speed
    dbl_speed = 1;
    send_frame(32'hB4, 8, 0, 0, 0, 1, 32, 32, -1, "R3"); idle(60);
    send_frame(32'h2D, 8, 0, 0, 0, 1, 32, 32, -1, "R3"); idle(60);
    send_frame(32'h0F, 8, 0, 0, 0, 1, 32, 32, 5, "R10"); idle(60);
    tdiv = 8;
    send_frame(32'hF0, 8, 0, 0, 0, 1, 64, 64, 2, "R10"); idle(100);

    // R12 rate mismatch, longest frame
    char_sel = 3'd4; par_en = 1; par_odd = 0;
    send_frame(32'h155, 9, 1, 0, 0, 1, 63, 63, -1, "R12"); idle(100);
    send_frame(32'h0AA, 9, 1, 0, 0, 1, 65, 65, -1, "R12"); idle(100);
    dbl_speed = 0; tdiv = 4;
    send_frame(32'h1E1, 9, 1, 0, 0, 1, 62, 62, -1, "R12"); idle(100);
    send_frame(32'h03E, 9, 1, 0, 0, 1, 66, 66, -1, "R12"); idle(100);
    par_en = 0; char_sel = 3'd3;

    // R13 configuration changed mid-frame
    fork
      send_frame(32'hD2, 8, 0, 0, 0, 1, 64, 64, -1, "R13");
      begin
        repeat (100) @(negedge clk);
        char_sel = 3'd0; par_en = 1; dbl_speed = 1;
      end
    join
    idle(100);
    char_sel = 3'd3; par_en = 0; dbl_speed = 0;
    idle(200);

    // every frame sent must have been reported
    chk(exp_data.size() == 0, "R11", "frames outstanding", exp_data.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule